// File: doc/BRIEF.md
# Anti-fuse One-Time-Programmable Byte Array Controller

This block drives a small one-time-programmable store whose cells start at 0 and can only ever be turned to 1. Software reaches it through a register port with separate write and read addresses. Power and start-up timing may only be changed right after a 32-bit unlock key has been written. Software then sets a program-pulse width in 10 ns units, loads a combined address/data word, and starts a program operation. It polls a busy flag until that flag clears.

A sequencer carries out each operation. On the first program after power-on it waits out the supply start-up time. It then holds a program pulse for the configured width and finally merges the data byte into the addressed cell byte with a bitwise OR. Eight byte-wide read registers show the array contents. A behavioural cell model, in which bits cannot return to 0, is part of the block.

Top module: `afuse_prog_ctrl`

## Requirements
- R1: After reset, all eight data registers read 0x00, busy is 0, the power register reads 0, the start-up register reads the minimum (16 cycles by default) and the pulse register reads 0.
- R2: Writes to the power register (write address 1) and to the start-up register (write address 2) take effect only if the key 0xAB12DFCD was written to the key register (address 0) before them. Without a key, or after a wrong key, they leave the register unchanged.
- R3: A correct key opens exactly one write to the power or start-up register. A second such write without a new key is ignored.
- R4: An accepted start-up value is stored only when it is greater than the minimum. Otherwise the minimum is stored.
- R5: A write to the pulse register (address 3) ORs the written bits into the stored value.
- R6: The word register (address 4) holds the target address in bits 15:8 and the data byte in bits 7:0. Writing 1 to bit 0 of the control register (address 5) starts a program. The control register reads back busy in bit 2, and `prog_busy` mirrors it.
- R7: After a program completes, the addressed byte equals its old value ORed with the data byte. Read addresses 8 to 15 return cell bytes 0 to 7 in bits 7:0, and no bit ever returns from 1 to 0.
- R8: A start while the power bit (bit 0 of the power register) is 0 is ignored.
- R9: A start whose word address is 8 or more is ignored.
- R10: A start issued while busy is ignored, and the operation in flight keeps its own address and data.
- R11: The first program after power-on is busy for start-up + pulse + 1 clock cycles. Later programs are busy for pulse + 1 cycles. Pulse cycles are the pulse units times CLK_MHZ/100 (at least 1).
- R12: Clearing the power bit forgets the completed start-up, so the first program after the next power-on waits out the start-up time again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| prog_busy | output | 1 | High while a program operation runs |

## Verification
Programs are tried on a fresh byte (0x5A into byte 0), on a byte that already holds bits (0x0F, then 0xA0 on top), and on the last byte (0x80 into byte 7). Together these separate a true OR merge from a plain overwrite and catch address decode slips at both ends of the array. Busy lengths are measured on the first program after power-on and on later ones, and again after a power cycle. This tells a one-time start-up wait apart from a wait on every program, and from one that survives power-off. Key handling is tried with no key, a wrong key, a valid key used twice and a valid key with a too-small start-up value. This separates gating, one-shot relock and clamping from one another.

// File: rtl/afuse_pkg.sv
package afuse_pkg;
    localparam logic [31:0] UNLOCK_KEY = 32'hAB12DFCD;

    localparam logic [3:0] RA_KEY    = 4'd0;
    localparam logic [3:0] RA_PWR    = 4'd1;
    localparam logic [3:0] RA_SETTLE = 4'd2;
    localparam logic [3:0] RA_PULSE  = 4'd3;
    localparam logic [3:0] RA_WORD   = 4'd4;
    localparam logic [3:0] RA_CTRL   = 4'd5;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SETTLE,
        S_PULSE,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/afuse_cfg.sv
module afuse_cfg
    import afuse_pkg::*;
#(
    parameter int SETTLE_W   = 24,
    parameter int MIN_SETTLE = 16,
    parameter int PULSE_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [3:0]          wr_addr,
    input  logic [31:0]         wr_data,
    output logic                power_on,
    output logic [SETTLE_W-1:0] settle_len,
    output logic [PULSE_W-1:0]  pulse_units,
    output logic [15:0]         word
);
    localparam logic [SETTLE_W-1:0] MIN_S = SETTLE_W'(MIN_SETTLE);

    typedef struct packed {
        logic                unlocked;
        logic                power;
        logic [SETTLE_W-1:0] settle;
        logic [PULSE_W-1:0]  pulse;
        logic [15:0]         word;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                RA_KEY: cfg_d.unlocked = (wr_data == UNLOCK_KEY);
                RA_PWR: if (cfg_q.unlocked) begin
                    cfg_d.power    = wr_data[0];
                    cfg_d.unlocked = 1'b0;
                end
                RA_SETTLE: if (cfg_q.unlocked) begin
                    cfg_d.settle   = (wr_data[SETTLE_W-1:0] > MIN_S) ? wr_data[SETTLE_W-1:0] : MIN_S;
                    cfg_d.unlocked = 1'b0;
                end
                RA_PULSE: cfg_d.pulse = cfg_q.pulse | wr_data[PULSE_W-1:0];
                RA_WORD:  cfg_d.word  = wr_data[15:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.unlocked <= 1'b0;
            cfg_q.power    <= 1'b0;
            cfg_q.settle   <= MIN_S;
            cfg_q.pulse    <= '0;
            cfg_q.word     <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign power_on    = cfg_q.power;
    assign settle_len  = cfg_q.settle;
    assign pulse_units = cfg_q.pulse;
    assign word        = cfg_q.word;

    a_r4_settle_floor: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.settle >= MIN_S);

    a_r5_pulse_only_grows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == RA_PULSE |=> (cfg_q.pulse & $past(cfg_q.pulse)) == $past(cfg_q.pulse));

    a_r2_locked_power_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == RA_PWR && !cfg_q.unlocked |=> $stable(cfg_q.power));
endmodule

// File: rtl/afuse_seq.sv
module afuse_seq
    import afuse_pkg::*;
#(
    parameter int SETTLE_W     = 24,
    parameter int PULSE_W      = 16,
    parameter int CYC_PER_10NS = 1,
    parameter int DEPTH        = 8,
    parameter int ADDR_W       = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_req,
    input  logic                power_on,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic [PULSE_W-1:0]  pulse_units,
    input  logic [15:0]         word,
    output logic                busy,
    output logic                prog_en,
    output logic [ADDR_W-1:0]   prog_addr,
    output logic [7:0]          prog_data
);
    localparam int CNT_W = ((SETTLE_W > PULSE_W) ? SETTLE_W : PULSE_W) + 8;

    typedef struct packed {
        seq_state_e         state;
        logic [CNT_W-1:0]   cnt;
        logic               settled;
        logic [ADDR_W-1:0]  addr;
        logic [7:0]         data;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CNT_W-1:0] pulse_len;
    logic [CNT_W-1:0] cnt_inc;
    logic             start_ok;

    always_comb begin
        pulse_len = CNT_W'(pulse_units) * CNT_W'(CYC_PER_10NS);
        cnt_inc   = seq_q.cnt + 1'b1;
        start_ok  = start_req && seq_q.state == S_IDLE && power_on && (word[15:8] < 8'(DEPTH));
        seq_d     = seq_q;
        case (seq_q.state)
            S_IDLE: if (start_ok) begin
                seq_d.addr  = word[8 +: ADDR_W];
                seq_d.data  = word[7:0];
                seq_d.cnt   = '0;
                seq_d.state = seq_q.settled ? S_PULSE : S_SETTLE;
            end
            S_SETTLE: if (cnt_inc >= CNT_W'(settle_len)) begin
                seq_d.state   = S_PULSE;
                seq_d.cnt     = '0;
                seq_d.settled = 1'b1;
            end else begin
                seq_d.cnt = cnt_inc;
            end
            S_PULSE: if (cnt_inc >= pulse_len) begin
                seq_d.state = S_DONE;
            end else begin
                seq_d.cnt = cnt_inc;
            end
            default: seq_d.state = S_IDLE;
        endcase
        if (!power_on) seq_d.settled = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state   <= S_IDLE;
            seq_q.cnt     <= '0;
            seq_q.settled <= 1'b0;
            seq_q.addr    <= '0;
            seq_q.data    <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.state != S_IDLE);
    assign prog_en   = (seq_q.state == S_DONE);
    assign prog_addr = seq_q.addr;
    assign prog_data = seq_q.data;

    a_r10_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start_req |=> $stable(seq_q.addr) && $stable(seq_q.data));

    a_r9_bad_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.state == S_IDLE && start_req && word[15:8] >= 8'(DEPTH) |=> seq_q.state == S_IDLE);

    a_r8_unpowered_idle: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.state == S_IDLE && !power_on |=> seq_q.state == S_IDLE);

    a_r12_power_off_forgets: assert property (@(posedge clk) disable iff (!rst_n)
        !power_on |=> !seq_q.settled);
endmodule

// File: rtl/afuse_array.sv
module afuse_array #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_en,
    input  logic [ADDR_W-1:0]  prog_addr,
    input  logic [7:0]         prog_data,
    output logic [DEPTH*8-1:0] cells
);
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (prog_en && prog_addr == ADDR_W'(i)) mem_d[i] = mem_q[i] | prog_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        assign cells[g*8 +: 8] = mem_q[g];

        a_r7_no_unprogram: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mem_q[g]) & ~mem_q[g]) == 8'h00);
    end
endmodule

// File: rtl/afuse_prog_ctrl.sv
module afuse_prog_ctrl
    import afuse_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int SETTLE_W   = 24,
    parameter int MIN_SETTLE = 16,
    parameter int PULSE_W    = 16,
    parameter int CLK_MHZ    = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [3:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    output logic        prog_busy
);
    localparam int ADDR_W       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CYC_PER_10NS = (CLK_MHZ >= 200) ? (CLK_MHZ / 100) : 1;

    logic                power_on;
    logic [SETTLE_W-1:0] settle_len;
    logic [PULSE_W-1:0]  pulse_units;
    logic [15:0]         word;
    logic                start_req;
    logic                prog_en;
    logic [ADDR_W-1:0]   prog_addr;
    logic [7:0]          prog_data;
    logic [DEPTH*8-1:0]  cells;

    assign start_req = reg_wr && reg_waddr == RA_CTRL && reg_wdata[0];

    afuse_cfg #(
        .SETTLE_W  (SETTLE_W),
        .MIN_SETTLE(MIN_SETTLE),
        .PULSE_W   (PULSE_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wr_addr    (reg_waddr),
        .wr_data    (reg_wdata),
        .power_on   (power_on),
        .settle_len (settle_len),
        .pulse_units(pulse_units),
        .word       (word)
    );

    afuse_seq #(
        .SETTLE_W    (SETTLE_W),
        .PULSE_W     (PULSE_W),
        .CYC_PER_10NS(CYC_PER_10NS),
        .DEPTH       (DEPTH),
        .ADDR_W      (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .power_on   (power_on),
        .settle_len (settle_len),
        .pulse_units(pulse_units),
        .word       (word),
        .busy       (prog_busy),
        .prog_en    (prog_en),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data)
    );

    afuse_array #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_en  (prog_en),
        .prog_addr(prog_addr),
        .prog_data(prog_data),
        .cells    (cells)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_raddr[3]) begin
            for (int i = 0; i < DEPTH && i < 8; i++) begin
                if (reg_raddr[2:0] == 3'(i)) reg_rdata[7:0] = cells[i*8 +: 8];
            end
        end else begin
            case (reg_raddr)
                RA_PWR:    reg_rdata[0]          = power_on;
                RA_SETTLE: reg_rdata[SETTLE_W-1:0] = settle_len;
                RA_PULSE:  reg_rdata[PULSE_W-1:0]  = pulse_units;
                RA_WORD:   reg_rdata[15:0]       = word;
                RA_CTRL:   reg_rdata[2]          = prog_busy;
                default: ;
            endcase
        end
    end
endmodule

// File: tb/afuse_prog_ctrl_test.sv
module afuse_prog_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        prog_busy;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [3:0]  q_ra  [$];
    logic [31:0] q_exp [$];
    string       q_tag [$];
    logic [7:0]  model [8];

    localparam logic [31:0] KEY = 32'hAB12DFCD;

    always #4 clk = ~clk;

    afuse_prog_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .prog_busy(prog_busy)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // monitor: pops scoreboard items and compares against the read port
    initial begin
        forever begin
            wait (q_exp.size() > 0);
            @(negedge clk);
            reg_raddr = q_ra[0];
            #1;
            check(q_tag[0], reg_rdata, q_exp[0]);
            void'(q_ra.pop_front());
            void'(q_exp.pop_front());
            void'(q_tag.pop_front());
        end
    end

    task automatic expect_rd(logic [3:0] ra, logic [31:0] exp, string tag);
        q_ra.push_back(ra);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        wait (q_exp.size() == 0);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic expect_cells(string tag);
        for (int i = 0; i < 8; i++) expect_rd(4'(8 + i), {24'h0, model[i]}, tag);
    endtask

    // driver: program a byte, measure busy length, push expected cell
    task automatic prog(int a, logic [7:0] d, int exp_busy, string tag);
        int cyc = 0;
        wr(4'd4, {16'h0, 8'(a), d});
        wr(4'd5, 32'h1);
        while (prog_busy) begin
            cyc++;
            @(negedge clk);
        end
        check({tag, " busy length"}, cyc, exp_busy);
        model[a] = model[a] | d;
        expect_rd(4'(8 + a), {24'h0, model[a]}, tag);
    endtask

    initial begin
        #(8 * 100000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", {31'h0, prog_busy}, 32'h0);
        expect_cells("R1 cells");
        expect_rd(4'd1, 32'h0, "R1 power");
        expect_rd(4'd2, 32'd16, "R1 settle");
        expect_rd(4'd3, 32'h0, "R1 pulse");
        expect_rd(4'd5, 32'h0, "R1 ctrl");

        // R2 gating
        wr(4'd2, 32'd40);
        expect_rd(4'd2, 32'd16, "R2 no key");
        wr(4'd0, 32'hAB12DFCC);
        wr(4'd2, 32'd40);
        expect_rd(4'd2, 32'd16, "R2 wrong key settle");
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h1);
        expect_rd(4'd1, 32'h0, "R2 wrong key power");

        // R8 start while unpowered
        wr(4'd4, 32'h0011);
        wr(4'd5, 32'h1);
        check("R8 busy", {31'h0, prog_busy}, 32'h0);
        expect_rd(4'd8, 32'h0, "R8 cell0");

        // R4 clamp
        wr(4'd0, KEY);
        wr(4'd2, 32'd5);
        expect_rd(4'd2, 32'd16, "R4 clamp");

        // R3 one-shot unlock
        wr(4'd0, KEY);
        wr(4'd2, 32'd20);
        expect_rd(4'd2, 32'd20, "R3 accepted");
        wr(4'd2, 32'd30);
        expect_rd(4'd2, 32'd20, "R3 relocked");

        // R5 pulse OR
        wr(4'd3, 32'd3);
        wr(4'd3, 32'd4);
        expect_rd(4'd3, 32'd7, "R5 pulse or");

        // R12 power on
        wr(4'd0, KEY);
        wr(4'd1, 32'h1);
        expect_rd(4'd1, 32'h1, "R12 power on");

        // R7 / R11 programs: first 20+7+1, later 7+1
        prog(0, 8'h5A, 28, "R11 first R7");
        expect_cells("R7 after 0x5A");
        prog(0, 8'h0F, 8, "R11 later R7 merge");
        prog(7, 8'h80, 8, "R7 top byte");
        prog(0, 8'hA0, 8, "R7 fill");

        // R6 word layout and busy in control bit 2
        wr(4'd4, 32'h0305);
        expect_rd(4'd4, 32'h0305, "R6 word");
        wr(4'd5, 32'h1);
        expect_rd(4'd5, 32'h4, "R6 ctrl busy");
        wait (!prog_busy);
        @(negedge clk);
        model[3] = model[3] | 8'h05;
        expect_rd(4'd5, 32'h0, "R6 ctrl idle");
        expect_rd(4'd11, {24'h0, model[3]}, "R6 cell3");

        // R9 bad address
        wr(4'd4, 32'h0955);
        wr(4'd5, 32'h1);
        check("R9 busy", {31'h0, prog_busy}, 32'h0);
        expect_cells("R9 cells");

        // R10 start while busy
        wr(4'd4, 32'h0211);
        wr(4'd5, 32'h1);
        wr(4'd4, 32'h0422);
        wr(4'd5, 32'h1);
        wait (!prog_busy);
        @(negedge clk);
        check("R10 idle", {31'h0, prog_busy}, 32'h0);
        model[2] = model[2] | 8'h11;
        expect_cells("R10 cells");

        // R12 power cycle
        wr(4'd0, KEY);
        wr(4'd1, 32'h0);
        wr(4'd4, 32'h0644);
        wr(4'd5, 32'h1);
        check("R12 off busy", {31'h0, prog_busy}, 32'h0);
        wr(4'd0, KEY);
        wr(4'd1, 32'h1);
        prog(6, 8'h44, 28, "R12 resettle");
        prog(5, 8'h21, 8, "R12 after resettle");
        expect_cells("R12 cells");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule